// File: doc/BRIEF.md
# Framed Serial DAC Command Receiver

This block is the digital front end of a serially programmed voltage DAC. A fast system clock samples the four serial pins: a bit clock, a frame-sync strobe, an active-low select and a data line. The block shifts a 16-bit command word in with the most significant bit first. When the frame closes, it moves the word into a holding latch. From that latch it drives the 8-bit converter code, a settling-speed select and a power-down flag to the analog stage. It pulses an update strobe for one cycle on each write.

A frame opens on a falling edge of frame sync and captures one bit on every falling edge of the bit clock. A full frame of 16 bits is committed on the next rising bit-clock edge. Frame sync rising early commits whatever has been shifted in so far. The select line may be held low permanently for three-wire use. In four-wire use it gates the block, and raising it mid-frame abandons the frame.

Top module: `dacword_rx`

## Requirements
- R1: After reset the code output, the speed select, the power-down flag and the update strobe are all zero.
- R2: In a 16-bit frame the first bit received is word bit 15. The code output takes word bits 11 down to 4, with bit 11 as its most significant bit.
- R3: Word bit 14 drives the speed select (1 = fast, 0 = slow) and word bit 13 drives the power-down flag (1 = powered down). Word bits 15, 12 and 3 down to 0 affect no output.
- R4: After the sixteenth falling bit-clock edge the outputs do not change until the next rising bit-clock edge. They take the new word within a few system cycles of that edge.
- R5: If frame sync rises after k bits (0 < k < 16), the latch takes the shift register as it stands. The k received bits sit right-aligned in it, the last one at bit 0, and the remaining upper bits are zero.
- R6: While the select pin is high, bit-clock, frame-sync and data activity cause no update and leave all outputs unchanged.
- R7: Raising the select pin mid-frame abandons the frame, with no update. The next frame, opened by a new frame-sync fall, counts its bits from zero.
- R8: With the select pin held low throughout, successive frames each open on a frame-sync fall and each update the outputs.
- R9: The update strobe is high for exactly one system cycle per latch write, and the outputs change only in that cycle.
- R10: Bit-clock edges when no frame is open cause no update.
- R11: A frame-sync rise after a full frame has already been committed causes no second update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial bit clock; data is captured on its falling edge |
| fs_i | input | 1 | Frame sync; falling edge opens a frame, rising edge closes it early |
| csn_i | input | 1 | Active-low device select |
| din_i | input | 1 | Serial data, most significant bit first |
| code_o | output | 8 | Latched converter code |
| fast_o | output | 1 | Settling-speed select, 1 = fast |
| pdown_o | output | 1 | Power-down flag, 1 = powered down |
| upd_o | output | 1 | One-cycle strobe on each latch write |

## Verification
The assertions rely on four conditions on the inputs:
- Every pin is synchronized with the same latency, so the data line must hold steady across the synchronized falling bit-clock edge.
- Each bit-clock phase must last at least two system cycles.
- A frame-sync edge must never land in the same system cycle as a bit-clock edge.
- Reset must be applied at time zero.

The stimulus meets these conditions. It drives every pin on the falling system-clock edge and holds each bit-clock phase for four system cycles. It changes the data line only together with a rising bit-clock edge, and it moves frame sync only while the bit clock rests high with idle cycles on both sides.

// File: rtl/dacword_rx.sv
module dacword_rx #(
  parameter int WORD_W      = 16,
  parameter int CODE_W      = 8,
  parameter int CODE_LSB    = 4,
  parameter int SPEED_BIT   = 14,
  parameter int PDOWN_BIT   = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              fs_i,
  input  logic              csn_i,
  input  logic              din_i,
  output logic [CODE_W-1:0] code_o,
  output logic              fast_o,
  output logic              pdown_o,
  output logic              upd_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [3:0] PIN_IDLE = 4'b1110;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES:0][3:0] pipe;
  logic [3:0] now_v, was_v;
  logic sclk_fall, sclk_rise, fs_fall, fs_rise, cs_on, din_s;
  logic open_q, full_q, commit;
  logic [CNT_W-1:0] cnt_q;
  logic [WORD_W-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe <= {(SYNC_STAGES+1){PIN_IDLE}};
    else        pipe <= {pipe[SYNC_STAGES-1:0], {sclk_i, fs_i, csn_i, din_i}};

  assign now_v     = pipe[SYNC_STAGES-1];
  assign was_v     = pipe[SYNC_STAGES];
  assign sclk_fall =  was_v[3] & ~now_v[3];
  assign sclk_rise = ~was_v[3] &  now_v[3];
  assign fs_fall   =  was_v[2] & ~now_v[2];
  assign fs_rise   = ~was_v[2] &  now_v[2];
  assign cs_on     = ~now_v[1];
  assign din_s     =  now_v[0];

  assign commit = cs_on & open_q & ((full_q & sclk_rise) | fs_rise);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      open_q  <= 1'b0;
      full_q  <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (!cs_on) begin
      open_q <= 1'b0;
      full_q <= 1'b0;
      cnt_q  <= '0;
    end else if (fs_fall) begin
      open_q  <= 1'b1;
      full_q  <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (commit) begin
      open_q <= 1'b0;
      full_q <= 1'b0;
      cnt_q  <= '0;
    end else if (open_q && !full_q && sclk_fall) begin
      shreg_q <= {shreg_q[WORD_W-2:0], din_s};
      cnt_q   <= cnt_q + 1'b1;
      full_q  <= (cnt_q == LAST_CNT);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_o  <= '0;
      fast_o  <= 1'b0;
      pdown_o <= 1'b0;
      upd_o   <= 1'b0;
    end else begin
      upd_o <= commit;
      if (commit) begin
        code_o  <= shreg_q[CODE_LSB +: CODE_W];
        fast_o  <= shreg_q[SPEED_BIT];
        pdown_o <= shreg_q[PDOWN_BIT];
      end
    end

  p_upd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  p_moves_with_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(code_o) && $stable(fast_o) && $stable(pdown_o)) |-> upd_o);

  p_cs_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_on |=> (!upd_o && $stable(code_o) && $stable(fast_o) && $stable(pdown_o)));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));

  p_wait_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !sclk_rise && !fs_rise) |=> !upd_o);

  p_full_at_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (cnt_q == CNT_W'(WORD_W)));
endmodule

// File: tb/test_dacword_rx.sv
`timescale 1ns/1ps
module test_dacword_rx;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, fs = 1'b1, csn = 1'b0, din = 1'b0;
  logic [7:0] code;
  logic fast, pdown, upd;
  int tests = 0, fails = 0, upd_cnt = 0;
  logic upd_prev = 1'b0;

  always #2.5 clk = ~clk;

  dacword_rx i_dacword_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .fs_i(fs), .csn_i(csn), .din_i(din),
    .code_o(code), .fast_o(fast), .pdown_o(pdown), .upd_o(upd)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (upd) upd_cnt++;
    if (upd && upd_prev) chk("R9 strobe longer than one cycle", 1, 0);
    upd_prev = upd;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame();
    fs = 1'b0; idle(6);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      din = w[15-i];
      idle(HALF); sclk = 1'b0; idle(HALF);
      if (i != n-1) sclk = 1'b1;
    end
  endtask

  task automatic sclk_up();
    sclk = 1'b1; idle(10);
  endtask

  task automatic fs_up();
    fs = 1'b1; idle(10);
  endtask

  task automatic expect_word(input string req, input logic [15:0] sh);
    chk({req, " code"}, code, sh[11:4]);
    chk({req, " fast"}, fast, sh[14]);
    chk({req, " pdown"}, pdown, sh[13]);
  endtask

  task automatic full_frame(input logic [15:0] w);
    open_frame(); shift_bits(w, 16); sclk_up(); fs_up();
  endtask

  task automatic t_reset();
    chk("R1 code", code, 0); chk("R1 fast", fast, 0);
    chk("R1 pdown", pdown, 0); chk("R1 upd", upd, 0);
  endtask

  task automatic t_full_frames();
    int c0 = upd_cnt;
    full_frame(16'h5A50); expect_word("R2 R3 word 5A50", 16'h5A50);
    full_frame(16'hA3CF); expect_word("R3 word A3CF", 16'hA3CF);
    full_frame(16'hFFFF); expect_word("R2 word FFFF", 16'hFFFF);
    full_frame(16'h0000); expect_word("R8 word 0000", 16'h0000);
    chk("R8 one update per frame", upd_cnt - c0, 4);
  endtask

  task automatic t_update_timing();
    int c0 = upd_cnt;
    open_frame(); shift_bits(16'h4C30, 16); idle(20);
    chk("R4 no update before rise", upd_cnt - c0, 0);
    chk("R4 code held before rise", code, 8'h00);
    sclk_up();
    chk("R4 update after rise", upd_cnt - c0, 1);
    expect_word("R4 word 4C30", 16'h4C30);
    fs_up();
    chk("R11 no second update", upd_cnt - c0, 1);
  endtask

  task automatic t_early_fs();
    int c0 = upd_cnt;
    open_frame(); shift_bits(16'hABCD, 12); sclk = 1'b1; idle(6); fs_up();
    chk("R5 early update count", upd_cnt - c0, 1);
    expect_word("R5 twelve bits", 16'hABCD >> 4);
    open_frame(); shift_bits(16'hE7FF, 5); sclk = 1'b1; idle(6); fs_up();
    expect_word("R5 five bits", 16'hE7FF >> 11);
  endtask

  task automatic t_cs_ignore();
    int c0;
    full_frame(16'h3120);
    c0 = upd_cnt;
    csn = 1'b1; idle(6);
    open_frame(); shift_bits(16'h6FF0, 16); sclk_up(); fs_up();
    chk("R6 no update while deselected", upd_cnt - c0, 0);
    expect_word("R6 outputs unchanged", 16'h3120);
    csn = 1'b0; idle(6);
  endtask

  task automatic t_abort();
    int c0 = upd_cnt;
    open_frame(); shift_bits(16'hFFFF, 7); sclk = 1'b1; idle(4);
    csn = 1'b1; idle(10);
    fs_up();
    chk("R7 abort gives no update", upd_cnt - c0, 0);
    expect_word("R7 latch kept", 16'h3120);
    csn = 1'b0; idle(6);
    full_frame(16'h0120);
    chk("R7 next frame updates once", upd_cnt - c0, 1);
    expect_word("R7 count restarted", 16'h0120);
  endtask

  task automatic t_stray_sclk();
    int c0 = upd_cnt;
    shift_bits(16'hFFFF, 16); sclk_up();
    chk("R10 no update without frame", upd_cnt - c0, 0);
    expect_word("R10 outputs unchanged", 16'h0120);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1; idle(8);
    t_reset();
    t_full_frames();
    t_update_timing();
    t_early_fs();
    t_cs_ignore();
    t_abort();
    t_stray_sclk();
    idle(10);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule